// File: doc/BRIEF.md
# Transmit Reset Sequencer

This block brings a transmit-only serial transceiver group out of reset after power-up in a fixed order. It first holds the transmit PLL in power-down for a programmable number of clock cycles. It then lets the PLL run so that it can acquire lock to its reference clock. Only after the PLL reports a steady lock does it release the transmit digital logic. The transmit digital reset stays asserted for the whole power-down and locking interval.

The lock indication from the PLL is asynchronous to the sequencer clock. It passes through a flop synchroniser and then through a filter that needs a run of consecutive high samples before it is accepted, so short glitches cannot release the datapath. If lock is lost after release, the digital reset is asserted again and the sequencer goes back to waiting for lock. The PLL is not powered down again in that case. A synchronous restart request replays the whole sequence, starting from power-down. A ready output tells downstream logic when it may send data.

Top module: `tx_rst_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pll_pd` is 1, `tx_dig_rst` is 1 and `tx_ready` is 0.
- R2: After `rst_n` rises, `pll_pd` stays high for exactly `PD_CYCLES` rising clock edges and goes low right after the `PD_CYCLES`-th edge.
- R3: `tx_dig_rst` is high in every cycle in which `pll_pd` is high.
- R4: After `pll_pd` goes low, `pll_pd` stays low and `tx_dig_rst` stays high for as long as the lock input stays low.
- R5: Lock passes through `SYNC_STAGES` flops. Once power-down is over, if `pll_locked` rises and then stays high, `tx_dig_rst` goes low right after the (`SYNC_STAGES` + `LOCK_CYCLES` + 1)-th rising edge after the input rose.
- R6: Lock must be high for `LOCK_CYCLES` + 1 consecutive synchronised samples. A shorter high pulse on `pll_locked` does not release `tx_dig_rst`, and a low sample restarts the count.
- R7: If the synchronised lock goes low while the datapath is released, `tx_dig_rst` goes high and `tx_ready` goes low on the next edge while `pll_pd` stays low. A later lock needs the full filter interval again before release.
- R8: A `restart_req` sampled high on an edge sets `pll_pd` and `tx_dig_rst` and clears `tx_ready` on that edge, whatever the state. The power-down interval then runs again in full: `pll_pd` falls right after the `PD_CYCLES`-th edge that follows the request edge.
- R9: `tx_ready` is high exactly when `tx_dig_rst` is low, and then `pll_pd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_req | input | 1 | Synchronous request to replay the full sequence |
| pll_locked | input | 1 | Asynchronous lock status from the transmit PLL |
| pll_pd | output | 1 | PLL power-down, active high |
| tx_dig_rst | output | 1 | Transmit digital reset, active high |
| tx_ready | output | 1 | Transmitter may send data |

## Verification
The bench measures the exact length of the power-down interval, both after reset and after a mid-sequence restart. A timer that is off by one, or that is not cleared by the restart, shows up as a wrong edge count. Lock pulses one sample short of the filter length are applied to catch a filter that releases early. A filter whose count survives a low sample would release on a later fragment, and the bench catches that too. Lock is dropped while the datapath is released, and the bench watches for the digital reset coming back without the PLL being powered down again. It also checks that a second full filter interval is required before the next release. Random lock toggling and rare restarts run against a cycle model built from the requirements, which exposes any wrong state ordering.

// File: rtl/tx_rst_seq_pkg.sv
package tx_rst_seq_pkg;

   typedef enum logic [1:0] {
      ST_PD   = 2'd0,
      ST_WAIT = 2'd1,
      ST_FILT = 2'd2,
      ST_RDY  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tx_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];

endmodule

// File: rtl/tx_rst_cnt.sv
module tx_rst_cnt #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic done
);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("tx_rst_cnt: LIMIT must be at least 2");
      end
   endgenerate

   localparam int W = $clog2(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   assign done = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (en && !done) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq
   import tx_rst_seq_pkg::*;
#(
   parameter int PD_CYCLES   = 1000,
   parameter int LOCK_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_req,
   input  logic pll_locked,
   output logic pll_pd,
   output logic tx_dig_rst,
   output logic tx_ready
);

   generate
      if (PD_CYCLES < 2) begin : g_bad_pd
         $error("tx_rst_seq: PD_CYCLES must be at least 2");
      end
      if (LOCK_CYCLES < 2) begin : g_bad_lock
         $error("tx_rst_seq: LOCK_CYCLES must be at least 2");
      end
   endgenerate

   seq_state_e state, st_nxt;
   logic       lock_s;
   logic       pd_done, filt_done;

   tx_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pll_locked),
      .q     (lock_s)
   );

   tx_rst_cnt #(.LIMIT(PD_CYCLES)) u_pd_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart_req || (state != ST_PD)),
      .en    (state == ST_PD),
      .done  (pd_done)
   );

   tx_rst_cnt #(.LIMIT(LOCK_CYCLES)) u_lock_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((state != ST_FILT) || !lock_s),
      .en    (state == ST_FILT),
      .done  (filt_done)
   );

   always_comb begin
      st_nxt = state;
      unique case (state)
         ST_PD:   if (pd_done) st_nxt = ST_WAIT;
         ST_WAIT: if (lock_s)  st_nxt = ST_FILT;
         ST_FILT: begin
            if (!lock_s)        st_nxt = ST_WAIT;
            else if (filt_done) st_nxt = ST_RDY;
         end
         ST_RDY:  if (!lock_s) st_nxt = ST_WAIT;
         default:              st_nxt = ST_PD;
      endcase
      if (restart_req) st_nxt = ST_PD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_PD;
         pll_pd     <= 1'b1;
         tx_dig_rst <= 1'b1;
         tx_ready   <= 1'b0;
      end else begin
         state      <= st_nxt;
         pll_pd     <= (st_nxt == ST_PD);
         tx_dig_rst <= (st_nxt != ST_RDY);
         tx_ready   <= (st_nxt == ST_RDY);
      end
   end

endmodule

// File: rtl/tx_rst_seq_chk.sv
module tx_rst_seq_chk #(
   parameter int PD_CYCLES = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic restart_req,
   input logic lock_s,
   input logic pll_pd,
   input logic tx_dig_rst,
   input logic tx_ready
);

   logic [31:0] pd_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pd_run <= 32'd0;
      else if (!pll_pd)              pd_run <= 32'd0;
      else if (pd_run != 32'hFFFF_FFFF) pd_run <= pd_run + 32'd1;
   end

   a_r3_rst_during_pd: assert property (@(posedge clk) disable iff (!rst_n)
      pll_pd |-> tx_dig_rst);

   a_r2_pd_min_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_pd) |-> (pd_run >= 32'(PD_CYCLES)));

   a_r5_release_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_dig_rst) |-> $past(lock_s));

   a_r7_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !lock_s && !restart_req) |=> (tx_dig_rst && !tx_ready && !pll_pd));

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> (pll_pd && tx_dig_rst && !tx_ready));

   a_r9_ready_decode: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!tx_dig_rst && !pll_pd));

   a_r9_ready_or_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready != tx_dig_rst));

endmodule

bind tx_rst_seq tx_rst_seq_chk #(.PD_CYCLES(PD_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .restart_req (restart_req),
   .lock_s      (lock_s),
   .pll_pd      (pll_pd),
   .tx_dig_rst  (tx_dig_rst),
   .tx_ready    (tx_ready)
);

// File: tb/tx_rst_seq_tb_top.sv
module tx_rst_seq_tb_top;

   localparam int PD   = 20;
   localparam int LK   = 6;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart_req = 1'b0;
   logic pll_locked = 1'b0;
   logic pll_pd, tx_dig_rst, tx_ready;

   int errors = 0;
   int checks = 0;
   bit done_flag = 1'b0;
   int cyc = 0;

   always #10 clk = ~clk;

   tx_rst_seq #(.PD_CYCLES(PD), .LOCK_CYCLES(LK), .SYNC_STAGES(SYNC)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_req (restart_req),
      .pll_locked  (pll_locked),
      .pll_pd      (pll_pd),
      .tx_dig_rst  (tx_dig_rst),
      .tx_ready    (tx_ready)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Cycle model built from the requirements: 0 power-down, 1 waiting, 2 ready
   logic m_s1, m_s2;
   int   mst, pcnt, run;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b0; m_s2 <= 1'b0; mst <= 0; pcnt <= 0; run <= 0;
      end else begin
         m_s1 <= pll_locked;
         m_s2 <= m_s1;
         if (restart_req) begin
            mst <= 0; pcnt <= 0; run <= 0;
         end else begin
            case (mst)
               0: if (pcnt == PD - 1) begin mst <= 1; pcnt <= 0; run <= 0; end
                  else pcnt <= pcnt + 1;
               1: if (m_s2) begin
                     if (run + 1 == LK + 1) mst <= 2;
                     run <= run + 1;
                  end else run <= 0;
               default: if (!m_s2) begin mst <= 1; run <= 0; end
            endcase
         end
      end
   end

   function automatic logic exp_pd(input int s);  return s == 0; endfunction
   function automatic logic exp_rst(input int s); return s != 2; endfunction

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done_flag) begin
         chk("R2", pll_pd, exp_pd(mst));
         chk("R5", tx_dig_rst, exp_rst(mst));
         chk("R9", tx_ready, !exp_rst(mst));
         if (pll_pd) chk("R3", tx_dig_rst, 1'b1);
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      int unsigned r;
      r = $urandom(32'd24681);

      // R1 reset values
      repeat (3) @(negedge clk);
      chk("R1", pll_pd, 1'b1);
      chk("R1", tx_dig_rst, 1'b1);
      chk("R1", tx_ready, 1'b0);
      rst_n = 1'b1;
      chk("R1", pll_pd, 1'b1);

      // R2 exact power-down length
      n = 0;
      do begin @(negedge clk); n++; end while (pll_pd && n < 200);
      chk_int("R2", n, PD);

      // R4 hold while no lock
      repeat (30) @(negedge clk);
      chk("R4", tx_dig_rst, 1'b1);
      chk("R4", pll_pd, 1'b0);

      // R6 glitch one sample too short
      pll_locked = 1'b1;
      repeat (LK) @(negedge clk);
      pll_locked = 1'b0;
      repeat (8) @(negedge clk);
      chk("R6", tx_dig_rst, 1'b1);
      // two fragments separated by one low sample
      pll_locked = 1'b1;
      repeat (LK - 1) @(negedge clk);
      pll_locked = 1'b0;
      @(negedge clk);
      pll_locked = 1'b1;
      repeat (LK - 1) @(negedge clk);
      pll_locked = 1'b0;
      repeat (8) @(negedge clk);
      chk("R6", tx_dig_rst, 1'b1);

      // R5 release latency
      pll_locked = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (tx_dig_rst && n < 200);
      chk_int("R5", n, SYNC + LK + 1);

      // R7 lock loss
      repeat (5) @(negedge clk);
      pll_locked = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7", tx_ready, 1'b1);
      @(negedge clk);
      chk("R7", tx_dig_rst, 1'b1);
      chk("R7", tx_ready, 1'b0);
      chk("R7", pll_pd, 1'b0);
      pll_locked = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (tx_dig_rst && n < 200);
      chk_int("R7", n, SYNC + LK + 1);

      // R8 restart from ready
      restart_req = 1'b1;
      @(negedge clk);
      restart_req = 1'b0;
      chk("R8", pll_pd, 1'b1);
      chk("R8", tx_dig_rst, 1'b1);
      chk("R8", tx_ready, 1'b0);
      n = 1;
      do begin @(negedge clk); n++; end while (pll_pd && n < 200);
      chk_int("R8", n, PD + 1);
      // R8 restart in the middle of power-down
      restart_req = 1'b1;
      @(negedge clk);
      restart_req = 1'b0;
      repeat (PD / 2) @(negedge clk);
      restart_req = 1'b1;
      @(negedge clk);
      restart_req = 1'b0;
      n = 1;
      do begin @(negedge clk); n++; end while (pll_pd && n < 200);
      chk_int("R8", n, PD + 1);

      // Random phase checked against the cycle model
      for (int i = 0; i < 4000; i++) begin
         r = $urandom % 1000;
         if (r < 40) pll_locked = ~pll_locked;
         restart_req = (r >= 995);
         @(negedge clk);
      end
      restart_req = 1'b0;
      repeat (5) @(negedge clk);

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule